// File: doc/BRIEF.md
# Wishbone Asynchronous SRAM Controller

This block is a Wishbone slave that serves single 32-bit read and write transfers from a host. It carries each one out on two 16-bit asynchronous static RAM devices placed side by side, which give a 256K-word by 32-bit memory. Transfers of 8, 16 and 32 bits are all supported through the four byte selects. The low device holds host data bits 15..0 and the high device holds bits 31..16. Each device has its own address bus, control strobes and upper and lower byte enables.

Every transfer follows the same fixed sequence. In a setup cycle the address, byte enables and (for a write) the data are placed on the bus. Next comes a strobe phase that lasts `WAIT_CYC` clocks, with write enable low on a write or output enable low on a read. A completion cycle follows, in which the acknowledge is high for one clock. On a read, the memory data is captured at the end of the strobe phase and shown on the host data output during that acknowledge cycle. On a write, the controller keeps driving the data bus through the completion cycle, so the data is still held when write enable rises.

Top module: `wb_sram_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active low), every memory chip enable, write enable, output enable and byte enable goes high (inactive), and `wb_ack` goes low.
- R2: A transfer starts only when `wb_stb` and `wb_cyc` are both high. If either one is high alone, no chip enable falls and no acknowledge is given.
- R3: Byte enables are active low. `wb_sel[0]` drives the lower byte enable of device 0 (data 7..0), `wb_sel[1]` the upper byte enable of device 0 (15..8), `wb_sel[2]` the lower byte enable of device 1 (23..16) and `wb_sel[3]` the upper byte enable of device 1 (31..24). A write changes only the selected bytes.
- R4: On a write (`wb_we`=1), write enable is low for exactly `WAIT_CYC` clocks. Output enable stays high for the whole transfer, and every strobe stays inside the time chip enable is low.
- R5: On a read (`wb_we`=0), output enable is low and write enable stays high. The stored data for the selected bytes is shown on `wb_dat_r` in the cycle in which `wb_ack` is high, and unselected byte lanes read as zero.
- R6: For a transfer launched while the controller is idle, `wb_ack` rises at the `WAIT_CYC`+2-th rising edge, counting the accepting edge as the first. It stays high for exactly one clock, and there is one acknowledge per transfer.
- R7: The controller drives the memory data bus with the write data from the setup cycle through the cycle after write enable rises. Write enable is never low, and never rises, while the bus is undriven.
- R8: The 18-bit word address `wb_adr` appears unchanged on both device address buses while chip enable is low.
- R9: If `wb_stb` or `wb_cyc` drops before the acknowledge, the controller gives no acknowledge for that transfer. Chip enable is back high by the second rising edge after the drop.
- R10: With `wb_cyc` held high and a new strobe raised in the acknowledge cycle, the next transfer is accepted on the second edge after the acknowledge. Its acknowledge comes `WAIT_CYC`+3 edges after the strobe rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Transfer strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_sel | input | 4 | Byte selects, bit 0 = bits 7..0 |
| wb_adr | input | 18 | Word address |
| wb_dat_w | input | 32 | Write data from host |
| wb_dat_r | output | 32 | Read data to host |
| wb_ack | output | 1 | Transfer complete, one clock |
| m0_dq | inout | 16 | Device 0 data bus (host bits 15..0) |
| m0_a | output | 18 | Device 0 address |
| m0_ce_n | output | 1 | Device 0 chip enable, active low |
| m0_we_n | output | 1 | Device 0 write enable, active low |
| m0_oe_n | output | 1 | Device 0 output enable, active low |
| m0_ub_n | output | 1 | Device 0 upper byte enable, active low |
| m0_lb_n | output | 1 | Device 0 lower byte enable, active low |
| m1_dq | inout | 16 | Device 1 data bus (host bits 31..16) |
| m1_a | output | 18 | Device 1 address |
| m1_ce_n | output | 1 | Device 1 chip enable, active low |
| m1_we_n | output | 1 | Device 1 write enable, active low |
| m1_oe_n | output | 1 | Device 1 output enable, active low |
| m1_ub_n | output | 1 | Device 1 upper byte enable, active low |
| m1_lb_n | output | 1 | Device 1 lower byte enable, active low |

## Verification
Full-word writes and reads set the baseline for data path and timing. Single-byte writes into each of the four lanes, followed by full-word read-back, separate a lane swap or a wrong device mapping from a correct one. Half-word and single-byte reads show whether unselected lanes are masked to zero. A high, irregular address catches truncated or swapped address lines. Back-to-back transfers with the cycle held, and a read abandoned mid-strobe, test the sequencer's re-entry and abort paths, while a strobe alone or a cycle alone shows that neither starts an access by itself.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared constants and the sequencer state type for the SRAM controller.
// Assumes two 16-bit devices forming one 32-bit word.
package sram_ctrl_pkg;
    localparam int DEV_N  = 2;
    localparam int DEV_W  = 16;
    localparam int BUS_W  = DEV_N * DEV_W;
    localparam int SEL_W  = BUS_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_DONE,
        ST_REL
    } seq_state_t;
endpackage

// File: rtl/sram_seq.sv
// Module: sram_seq
// Fixed-length access sequencer. Latches one host request, then runs
// setup -> strobe (WAIT_CYC clocks) -> done (ack), or on an abort
// strobe -> release -> idle. Assumes WAIT_CYC >= 1 and that the host holds
// its request stable until ack or until it drops strobe/cycle.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_adr,
    input  logic [BUS_W-1:0]  req_dat,
    output logic [ADDR_W-1:0] adr_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [BUS_W-1:0]  dat_q,
    output logic              active,
    output logic              we_act,
    output logic              oe_act,
    output logic              drv,
    output logic              ack,
    output logic              cap
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             wr_q;
    logic             last;

    assign last = (cnt == CNT_LAST);

    // State and strobe-length counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req) state <= ST_SETUP;
                end
                ST_SETUP: begin
                    state <= req ? ST_STROBE : ST_IDLE;
                end
                ST_STROBE: begin
                    if (!req)      state <= ST_REL;
                    else if (last) state <= ST_DONE;
                    else           cnt   <= cnt + 1'b1;
                end
                ST_DONE:  state <= ST_IDLE;
                ST_REL:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Request capture when a transfer is accepted in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            adr_q <= '0;
            sel_q <= '0;
            dat_q <= '0;
        end else if (state == ST_IDLE && req) begin
            wr_q  <= req_we;
            adr_q <= req_adr;
            sel_q <= req_sel;
            dat_q <= req_dat;
        end
    end

    // Strobe decode from the current state.
    always_comb begin
        active = (state != ST_IDLE);
        we_act = (state == ST_STROBE) && wr_q;
        oe_act = (state == ST_STROBE) && !wr_q;
        drv    = (state != ST_IDLE) && wr_q;
        ack    = (state == ST_DONE);
        cap    = (state == ST_STROBE) && !wr_q && req && last;
    end

    AST_ACK_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);                                                   // R6
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_act && oe_act));                                            // R5
    AST_CAP_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> ack);                                                    // R5
endmodule

// File: rtl/sram_lane_map.sv
// Module: sram_lane_map
// Maps host byte selects onto per-device active-low upper/lower byte
// enables. Select bit 2g feeds the lower enable and 2g+1 the upper enable
// of device g. Enables are only asserted while the access is active.
module sram_lane_map
    import sram_ctrl_pkg::*;
(
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic [DEV_N-1:0] ub_n,
    output logic [DEV_N-1:0] lb_n
);
    for (genvar g = 0; g < DEV_N; g++) begin : g_dev
        // Per-device byte enable decode.
        always_comb begin
            lb_n[g] = !(active && sel[2*g]);
            ub_n[g] = !(active && sel[2*g+1]);
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
// Module: sram_rd_capture
// Registers the memory data bus into the host read data on the capture
// strobe, zeroing byte lanes the host did not select. The value is held
// until the next capture.
module sram_rd_capture
    import sram_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [SEL_W-1:0] sel,
    input  logic [BUS_W-1:0] bus,
    output logic [BUS_W-1:0] dat
);
    for (genvar b = 0; b < SEL_W; b++) begin : g_byte
        // Masked capture of one byte lane.
        always_ff @(posedge clk) begin
            if (!rst_n)   dat[8*b +: 8] <= '0;
            else if (cap) dat[8*b +: 8] <= sel[b] ? bus[8*b +: 8] : 8'h00;
        end
    end

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap) |-> $stable(dat));                                   // R5
endmodule

// File: rtl/wb_sram_ctrl.sv
// Module: wb_sram_ctrl (top)
// Wishbone single-transfer slave driving two 16-bit asynchronous SRAMs as
// one 32-bit memory. Device 0 holds bits 15..0, device 1 bits 31..16.
// Assumes classic (non-pipelined) Wishbone: the request is held until ack.
module wb_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [3:0]        wb_sel,
    input  logic [ADDR_W-1:0] wb_adr,
    input  logic [31:0]       wb_dat_w,
    output logic [31:0]       wb_dat_r,
    output logic              wb_ack,
    inout  wire  [15:0]       m0_dq,
    output logic [ADDR_W-1:0] m0_a,
    output logic              m0_ce_n,
    output logic              m0_we_n,
    output logic              m0_oe_n,
    output logic              m0_ub_n,
    output logic              m0_lb_n,
    inout  wire  [15:0]       m1_dq,
    output logic [ADDR_W-1:0] m1_a,
    output logic              m1_ce_n,
    output logic              m1_we_n,
    output logic              m1_oe_n,
    output logic              m1_ub_n,
    output logic              m1_lb_n
);
    logic              req;
    logic [ADDR_W-1:0] adr_q;
    logic [SEL_W-1:0]  sel_q;
    logic [BUS_W-1:0]  dat_q;
    logic              active, we_act, oe_act, drv, cap;
    logic [DEV_N-1:0]  ub_n, lb_n;

    assign req = wb_stb && wb_cyc;

    sram_seq #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .req_we  (wb_we),
        .req_sel (wb_sel),
        .req_adr (wb_adr),
        .req_dat (wb_dat_w),
        .adr_q   (adr_q),
        .sel_q   (sel_q),
        .dat_q   (dat_q),
        .active  (active),
        .we_act  (we_act),
        .oe_act  (oe_act),
        .drv     (drv),
        .ack     (wb_ack),
        .cap     (cap)
    );

    sram_lane_map u_lane (
        .active (active),
        .sel    (sel_q),
        .ub_n   (ub_n),
        .lb_n   (lb_n)
    );

    sram_rd_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .sel   (sel_q),
        .bus   ({m1_dq, m0_dq}),
        .dat   (wb_dat_r)
    );

    // Memory-side strobes and addresses, identical on both devices.
    always_comb begin
        m0_a    = adr_q;
        m1_a    = adr_q;
        m0_ce_n = !active;
        m1_ce_n = !active;
        m0_we_n = !we_act;
        m1_we_n = !we_act;
        m0_oe_n = !oe_act;
        m1_oe_n = !oe_act;
        m0_ub_n = ub_n[0];
        m0_lb_n = lb_n[0];
        m1_ub_n = ub_n[1];
        m1_lb_n = lb_n[1];
    end

    // Tri-state data drivers, enabled only for writes.
    assign m0_dq = drv ? dat_q[15:0]  : 16'hzzzz;
    assign m1_dq = drv ? dat_q[31:16] : 16'hzzzz;

    AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !m0_we_n |-> drv);                                               // R7
    AST_WE_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m0_we_n) |-> drv);                                         // R7
    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!m0_we_n || !m0_oe_n) |-> !m0_ce_n);                            // R4
    AST_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        m0_ce_n |-> (m0_ub_n && m0_lb_n && m1_ub_n && m1_lb_n));         // R3
    AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m0_ce_n) |-> $past(wb_stb && wb_cyc));                     // R2
endmodule

// File: tb/sim_wb_sram_ctrl.sv
`timescale 1ns/100ps
module sim_wb_sram_ctrl;
    localparam int W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [3:0]  wb_sel = 4'h0;
    logic [17:0] wb_adr = '0;
    logic [31:0] wb_dat_w = '0;
    logic [31:0] wb_dat_r;
    logic        wb_ack;
    wire  [15:0] m0_dq, m1_dq;
    logic [17:0] m0_a, m1_a;
    logic        m0_ce_n, m0_we_n, m0_oe_n, m0_ub_n, m0_lb_n;
    logic        m1_ce_n, m1_we_n, m1_oe_n, m1_ub_n, m1_lb_n;

    always #2.5 clk = ~clk;

    wb_sram_ctrl #(.ADDR_W(18), .WAIT_CYC(W)) u0 (.*);

    // Behavioural SRAM devices (1K words each, low address bits).
    logic [15:0] mem0 [0:1023];
    logic [15:0] mem1 [0:1023];
    logic [31:0] ref_mem [0:1023];
    initial for (int i = 0; i < 1024; i++) begin
        mem0[i] = '0; mem1[i] = '0; ref_mem[i] = '0;
    end
    assign m0_dq = (!m0_ce_n && !m0_oe_n && m0_we_n) ? mem0[m0_a[9:0]] : 16'hzzzz;
    assign m1_dq = (!m1_ce_n && !m1_oe_n && m1_we_n) ? mem1[m1_a[9:0]] : 16'hzzzz;
    always @(posedge m0_we_n) if (!m0_ce_n) begin
        if (!m0_lb_n) mem0[m0_a[9:0]][7:0]  <= m0_dq[7:0];
        if (!m0_ub_n) mem0[m0_a[9:0]][15:8] <= m0_dq[15:8];
    end
    always @(posedge m1_we_n) if (!m1_ce_n) begin
        if (!m1_lb_n) mem1[m1_a[9:0]][7:0]  <= m1_dq[7:0];
        if (!m1_ub_n) mem1[m1_a[9:0]][15:8] <= m1_dq[15:8];
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [32:0] sb_q[$];
    logic [32:0] item;
    logic        ack_prev = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every acknowledge.
    always @(negedge clk) begin
        if (wb_ack) begin
            if (sb_q.size() == 0) check(0, "R6 ack without request", 1, 0);
            else begin
                item = sb_q.pop_front();
                if (item[32]) check(wb_dat_r == item[31:0], "R5 read data", wb_dat_r, item[31:0]);
                else          check(1'b1, "R6 write ack", 1, 1);
            end
            if (ack_prev) check(0, "R6 ack longer than one clock", 2, 1);
        end
        ack_prev = wb_ack;
    end

    // Driver: one transfer, pushes the expectation, checks strobes.
    task automatic xfer(input bit wr, input logic [3:0] sel, input logic [17:0] adr,
                        input logic [31:0] dat, input bit keep_cyc, input int exp_lat);
        logic [31:0] mask;
        int lat = 0, we_low = 0;
        bit oe_seen = 0, adr_ok = 1, bus_ok = 1, be_ok = 1;
        for (int b = 0; b < 4; b++) mask[8*b +: 8] = sel[b] ? 8'hFF : 8'h00;
        if (wr) begin
            ref_mem[adr[9:0]] = (ref_mem[adr[9:0]] & ~mask) | (dat & mask);
            sb_q.push_back({1'b0, 32'h0});
        end else
            sb_q.push_back({1'b1, ref_mem[adr[9:0]] & mask});
        wb_cyc = 1; wb_stb = 1; wb_we = wr; wb_sel = sel; wb_adr = adr; wb_dat_w = dat;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (!m0_we_n) we_low++;
            if (!m0_oe_n) oe_seen = 1;
            if (!m0_ce_n) begin
                if (m0_a != adr || m1_a != adr) adr_ok = 0;
                if ({m1_ub_n, m1_lb_n, m0_ub_n, m0_lb_n} != ~sel) be_ok = 0;
                if (wr && {m1_dq, m0_dq} != dat) bus_ok = 0;
            end
        end while (!wb_ack && lat < 100);
        wb_stb = 0;
        if (!keep_cyc) wb_cyc = 0;
        check(lat == exp_lat, keep_cyc ? "R10 ack latency" : "R6 ack latency", lat, exp_lat);
        check(we_low == (wr ? W : 0), "R4 write strobe length", we_low, wr ? W : 0);
        check(oe_seen == !wr, wr ? "R4 oe stays high on write" : "R5 oe low on read", oe_seen, !wr);
        check(adr_ok, "R8 address on both devices", adr_ok, 1);
        check(be_ok, "R3 byte enable mapping", be_ok, 1);
        if (wr) check(bus_ok, "R7 write data driven through release", bus_ok, 1);
        if (!keep_cyc) @(negedge clk);
    endtask

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            check(0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({m0_ce_n, m0_we_n, m0_oe_n, m0_ub_n, m0_lb_n,
               m1_ce_n, m1_we_n, m1_oe_n, m1_ub_n, m1_lb_n} == 10'h3FF,
              "R1 strobes inactive in reset", 0, 10'h3FF);
        check(wb_ack == 0, "R1 ack low in reset", wb_ack, 0);
        rst_n = 1;
        @(negedge clk);

        // R2: strobe alone, then cycle alone
        begin
            bit started = 0;
            wb_stb = 1;
            repeat (4) begin @(negedge clk); if (!m0_ce_n || wb_ack) started = 1; end
            wb_stb = 0; wb_cyc = 1;
            repeat (4) begin @(negedge clk); if (!m0_ce_n || wb_ack) started = 1; end
            wb_cyc = 0;
            check(!started, "R2 no access without stb and cyc", started, 0);
            @(negedge clk);
        end

        // Full-word write and read-back
        xfer(1, 4'hF, 18'd5, 32'hDEADBEEF, 0, W + 2);
        xfer(0, 4'hF, 18'd5, 32'h0, 0, W + 2);

        // R3: one byte into each lane, then full read
        xfer(1, 4'b0001, 18'd9, 32'hAAAAAA11, 0, W + 2);
        xfer(1, 4'b0010, 18'd9, 32'hAAAA22AA, 0, W + 2);
        xfer(1, 4'b0100, 18'd9, 32'hAA33AAAA, 0, W + 2);
        xfer(1, 4'b1000, 18'd9, 32'h44AAAAAA, 0, W + 2);
        xfer(0, 4'hF, 18'd9, 32'h0, 0, W + 2);
        check(ref_mem[9] == 32'h44332211, "R3 lanes assembled", ref_mem[9], 32'h44332211);

        // R3 / R5: half-word write, partial reads with zeroed lanes
        xfer(1, 4'b1100, 18'd5, 32'h12345678, 0, W + 2);
        xfer(0, 4'b1100, 18'd5, 32'h0, 0, W + 2);
        xfer(0, 4'b0001, 18'd5, 32'h0, 0, W + 2);
        xfer(0, 4'b0110, 18'd9, 32'h0, 0, W + 2);

        // R8: high irregular address
        xfer(1, 4'hF, 18'h2A5C3, 32'hCAFEF00D, 0, W + 2);
        xfer(0, 4'hF, 18'h2A5C3, 32'h0, 0, W + 2);

        // R10: back-to-back with cycle held
        xfer(1, 4'hF, 18'd17, 32'h0BADC0DE, 1, W + 2);
        xfer(0, 4'hF, 18'd17, 32'h0, 1, W + 3);
        xfer(0, 4'b0011, 18'd9, 32'h0, 0, W + 3);

        // R9: abandoned read
        begin
            bit acked = 0;
            wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_sel = 4'hF; wb_adr = 18'd5;
            repeat (2) begin @(posedge clk); @(negedge clk); end
            wb_stb = 0; wb_cyc = 0;
            repeat (2) begin @(negedge clk); if (wb_ack) acked = 1; end
            check(m0_ce_n && m1_ce_n, "R9 chip enable released after abort", m0_ce_n, 1);
            repeat (2) begin @(negedge clk); if (wb_ack) acked = 1; end
            check(!acked, "R9 no ack after abort", acked, 0);
        end
        xfer(0, 4'hF, 18'd9, 32'h0, 0, W + 2);

        check(sb_q.size() == 0, "R6 every transfer acknowledged", sb_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule